// File: doc/BRIEF.md
# Serial Output-Port Expander Controller

This block turns a daisy chain of 8-bit serial-in/parallel-out shift registers into a bank of `NUM_REGS*8` output-only general-purpose pins. It keeps a shadow copy of every pin. Every change to a pin sends the entire chain again in one serial frame over a clock, data and chip-select link. The rising edge of chip-select latches the storage registers of all the chips together. Reads return the shadow copy and never touch the chain.

A host issues one request at a time on a valid/ready handshake. The request carries an operation code, a pin number and a value. The block answers every accepted request with a one-cycle response pulse that carries a data bit and an error bit. After reset the shadow loads from the `DEFAULTS` parameter, which has one bit per pin with bit p belonging to pin p. The block drives the output-enable line active and shifts the default pattern out once before it accepts its first request.

Top module: `sr_gpio_expander`

## Requirements
- R1: The block has `NUM_REGS*8` pins, numbered 0 to `NUM_REGS*8-1`. Any request with a pin number at or above `NUM_REGS*8` gets a response with `rsp_error`=1. Such a request changes no shadow bit and starts no frame.
- R2: Each frame holds `cs_n` low from before the first rising `sclk` edge until after the last one. A frame has exactly `NUM_REGS*8` rising `sclk` edges. `sclk` stays low whenever `cs_n` is high.
- R3: Bits are sent MSB first. The first bit is pin `NUM_REGS*8-1` and the last is pin 0. So the byte sent first lands in the farthest register, and pin p ends up in register p/8, counted from the end nearest the controller, at bit p%8. `mosi` changes only while `sclk` is low.
- R4: A set request (`req_op`=1) writes `req_value` into the shadow bit of the pin and then sends one full frame. `req_ready` is low from the cycle after acceptance until the frame has ended. A request held valid during that time is accepted only after the frame ends.
- R5: A get request (`req_op`=0) returns the shadow bit on `rsp_data` with `rsp_error`=0. It starts no frame.
- R6: A make-input request (`req_op`=3) gets `rsp_error`=1. It changes no shadow bit and starts no frame.
- R7: A function query (`req_op`=4) on a valid pin returns `rsp_data`=1, meaning output, with `rsp_error`=0. It starts no frame.
- R8: A make-output request (`req_op`=2) with a value behaves exactly like a set request. Op codes 5 to 7 get `rsp_error`=1 and have no other effect.
- R9: Once reset is released, the shadow equals `DEFAULTS` and exactly one frame of that pattern goes out. `req_ready` stays low until that frame ends. `oe_n` is high in reset and low from the third clock after the release onward.
- R10: The `sclk` period is `CLK_DIV` system clocks, with equal high and low halves. `CLK_DIV` must be even and at least 2.
- R11: `frame_done` is high for exactly one cycle per frame, in the same cycle that `cs_n` returns high.
- R12: Every accepted request produces `rsp_valid` for one cycle, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | 0 get, 1 set, 2 make-output, 3 make-input, 4 function query |
| req_pin | input | PIN_W | Pin number |
| req_value | input | 1 | Value for set and make-output |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 1 | Pin value (get) or 1 for output (query) |
| rsp_error | output | 1 | Request was rejected |
| sclk | output | 1 | Serial clock to the chain |
| mosi | output | 1 | Serial data to the chain |
| cs_n | output | 1 | Frame select; its rising edge latches the outputs |
| oe_n | output | 1 | Active-low output enable for the chain |
| frame_done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench uses a three-register chain so that the byte reversal shows. It flips pins at both ends of the chain and one pin in the middle, then compares each captured frame against a model indexed by pin. A design that sends bytes in storage order, or LSB first, moves those pins into the wrong chip. Rejected and read-only requests must leave the frame count and the shadow unchanged. A request held valid during a frame must wait for that frame to end, or an update would corrupt a frame in flight. The bench also checks the reset frame, the length of the `sclk` half-periods, and that `frame_done` lines up with the rising edge of `cs_n`.

// File: rtl/sr_gpio_pkg.sv
`timescale 1ns/1ps
package sr_gpio_pkg;
  typedef enum logic [2:0] {
    OP_GET      = 3'd0,
    OP_SET      = 3'd1,
    OP_MAKE_OUT = 3'd2,
    OP_MAKE_IN  = 3'd3,
    OP_QUERY    = 3'd4
  } gpio_op_e;

  typedef enum logic [1:0] {
    CT_KICK = 2'd0,
    CT_BUSY = 2'd1,
    CT_IDLE = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_HIGH = 2'd2,
    SH_TAIL = 2'd3
  } shift_state_e;
endpackage

// File: rtl/sr_shadow.sv
`timescale 1ns/1ps
module sr_shadow #(
  parameter int NUM_REGS = 1,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0,
  parameter int PIN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PIN_W-1:0]      wr_pin,
  input  logic                  wr_val,
  input  logic [PIN_W-1:0]      rd_pin,
  output logic                  rd_bit,
  output logic [NUM_REGS*8-1:0] stream
);
  localparam int NPINS = NUM_REGS * 8;
  localparam int RW    = PIN_W - 3;
  localparam int EXT   = 1 << PIN_W;

  logic [RW-1:0] wr_reg;
  logic [2:0]    wr_bit;
  assign wr_reg = wr_pin[PIN_W-1:3];
  assign wr_bit = wr_pin[2:0];

  // Bank g holds the byte for chain register NUM_REGS-1-g, so bank 0 goes out first
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    localparam int REG = NUM_REGS - 1 - g;
    logic [7:0] byte_q, byte_d;
    logic       hit;

    assign hit = wr_en && (wr_reg == RW'(REG));

    always_comb begin
      byte_d = byte_q;
      if (hit) byte_d[wr_bit] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= DEFAULTS[REG*8 +: 8];
      else if (hit) byte_q <= byte_d;
    end

    assign stream[REG*8 +: 8] = byte_q;
  end

  logic [EXT-1:0] ext;
  always_comb begin
    ext = '0;
    ext[NPINS-1:0] = stream;
  end
  assign rd_bit = ext[rd_pin];

  // R5: the shadow only changes through a write
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stream));
endmodule

// File: rtl/sr_serializer.sv
`timescale 1ns/1ps
module sr_serializer
  import sr_gpio_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] data,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             done
);
  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LW  = $clog2(NBITS) + 1;

  shift_state_e     st_q, st_d;
  logic [NBITS-1:0] sr_q, sr_d;
  logic [LW-1:0]    left_q, left_d;
  logic [HCW-1:0]   hc_q, hc_d;
  logic             sclk_q, sclk_d, cs_q, cs_d, done_q, done_d;
  logic             half_end;

  assign half_end = (hc_q == HCW'(HALF - 1));

  always_comb begin
    st_d = st_q; sr_d = sr_q; left_d = left_q; hc_d = hc_q;
    sclk_d = sclk_q; cs_d = cs_q; done_d = 1'b0;
    case (st_q)
      SH_IDLE: if (start) begin
        sr_d = data; cs_d = 1'b0; hc_d = '0;
        left_d = LW'(NBITS - 1); st_d = SH_LOW;
      end
      SH_LOW: if (half_end) begin
        sclk_d = 1'b1; hc_d = '0; st_d = SH_HIGH;
      end else hc_d = hc_q + 1'b1;
      SH_HIGH: if (half_end) begin
        sclk_d = 1'b0; hc_d = '0;
        if (left_q == '0) st_d = SH_TAIL;
        else begin
          sr_d = sr_q << 1; left_d = left_q - 1'b1; st_d = SH_LOW;
        end
      end else hc_d = hc_q + 1'b1;
      SH_TAIL: if (half_end) begin
        cs_d = 1'b1; done_d = 1'b1; st_d = SH_IDLE;
      end else hc_d = hc_q + 1'b1;
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SH_IDLE; sr_q <= '0; left_q <= '0; hc_q <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0;
    end else begin
      st_q <= st_d; sr_q <= sr_d; left_q <= left_d; hc_q <= hc_d;
      sclk_q <= sclk_d; cs_q <= cs_d; done_q <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign done = done_q;
  assign mosi = cs_q ? 1'b0 : sr_q[NBITS-1];

  // R2: no clock edges outside a frame
  a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R3: data held while the clock is high
  a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R11: done is a single pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: done coincides with the latch edge
  a_r11_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));
endmodule

// File: rtl/sr_gpio_expander.sv
`timescale 1ns/1ps
module sr_gpio_expander
  import sr_gpio_pkg::*;
#(
  parameter int NUM_REGS = 1,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0,
  parameter int CLK_DIV = 4,
  localparam int NPINS = NUM_REGS * 8,
  localparam int PIN_W = $clog2(NPINS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [PIN_W-1:0] req_pin,
  input  logic             req_value,
  output logic             rsp_valid,
  output logic             rsp_data,
  output logic             rsp_error,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             oe_n,
  output logic             frame_done
);
  localparam int HALF = CLK_DIV / 2;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  ctrl_state_e      st_q, st_d;
  logic             oe_n_q;
  logic             rv_q, rd_q, re_q, rv_d, rd_d, re_d;
  logic             accept, pin_ok, is_write, wr_en, start, rd_bit;
  logic [NPINS-1:0] stream;

  assign req_ready = (st_q == CT_IDLE);
  assign accept    = req_valid && req_ready;
  assign pin_ok    = (req_pin < PIN_W'(NPINS));
  assign is_write  = (req_op == OP_SET) || (req_op == OP_MAKE_OUT);
  assign wr_en     = accept && pin_ok && is_write;

  sr_shadow #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS), .PIN_W(PIN_W)) u_shadow (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_pin(req_pin),
    .wr_val(req_value), .rd_pin(req_pin), .rd_bit(rd_bit), .stream(stream)
  );

  sr_serializer #(.NBITS(NPINS), .HALF(HALF)) u_ser (
    .clk(clk), .rst_n(rst_sn), .start(start), .data(stream),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(frame_done)
  );

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    case (st_q)
      CT_KICK: begin start = 1'b1; st_d = CT_BUSY; end
      CT_BUSY: if (frame_done) st_d = CT_IDLE;
      CT_IDLE: if (wr_en) st_d = CT_KICK;
      default: st_d = CT_IDLE;
    endcase
  end

  always_comb begin
    rv_d = accept;
    rd_d = 1'b0;
    re_d = 1'b0;
    if (accept) begin
      if (!pin_ok) re_d = 1'b1;
      else begin
        case (req_op)
          OP_GET:      rd_d = rd_bit;
          OP_SET:      rd_d = 1'b0;
          OP_MAKE_OUT: rd_d = 1'b0;
          OP_QUERY:    rd_d = 1'b1;
          default:     re_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= CT_KICK; oe_n_q <= 1'b1;
      rv_q <= 1'b0; rd_q <= 1'b0; re_q <= 1'b0;
    end else begin
      st_q <= st_d; oe_n_q <= 1'b0;
      rv_q <= rv_d; rd_q <= rd_d; re_q <= re_d;
    end
  end

  assign oe_n      = oe_n_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign rsp_error = re_q;

  // R4: no request is taken while a frame is on the wire
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_sn)
    !cs_n |-> !req_ready);
  // R1: out-of-range pins are rejected
  a_r1_range_error: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && !pin_ok) |=> (rsp_valid && rsp_error));
  // R6: make-input is rejected
  a_r6_input_error: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && req_op == OP_MAKE_IN) |=> (rsp_valid && rsp_error));
  // R7: query reports output
  a_r7_query_output: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && pin_ok && req_op == OP_QUERY) |=> (rsp_data && !rsp_error));
  // R12: one response per accepted request
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    accept |=> rsp_valid);
  // R9: output enable stays active once released
  a_r9_oe_held: assert property (@(posedge clk) disable iff (!rst_sn)
    !oe_n |=> !oe_n);
endmodule

// File: tb/sr_gpio_expander_test.sv
`timescale 1ns/1ps
module sr_gpio_expander_test;
  localparam int NR = 3;
  localparam int NP = NR * 8;
  localparam int PW = $clog2(NP) + 1;
  localparam int DIV = 4;
  localparam logic [NP-1:0] DEF = 24'hA53C01;

  logic clk, rst_n, req_valid, req_ready, req_value;
  logic [2:0] req_op;
  logic [PW-1:0] req_pin;
  logic rsp_valid, rsp_data, rsp_error, sclk, mosi, cs_n, oe_n, frame_done;

  int checks = 0, errors = 0;
  logic [NP-1:0] model;
  bit finished = 0;

  sr_gpio_expander #(.NUM_REGS(NR), .DEFAULTS(DEF), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pin(req_pin), .req_value(req_value),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_error(rsp_error),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .oe_n(oe_n), .frame_done(frame_done)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // serial monitor
  int frames = 0, bitcnt = 0, last_bits = 0;
  logic [NP-1:0] cap, last_frame;
  time last_rise = 0, pmin = 0, pmax = 0, lmin = 0, lmax = 0;
  always @(negedge cs_n) begin
    bitcnt = 0; cap = '0; pmin = 1000000; pmax = 0;
  end
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (bitcnt > 0) begin
        if ($time - last_rise < pmin) pmin = $time - last_rise;
        if ($time - last_rise > pmax) pmax = $time - last_rise;
      end
      last_rise = $time;
      cap = {cap[NP-2:0], mosi};
      bitcnt++;
    end
  end
  always @(posedge cs_n) begin
    if (rst_n) begin
      frames++; last_frame = cap; last_bits = bitcnt; lmin = pmin; lmax = pmax;
    end
  end

  // done pulse monitor
  int done_cnt = 0;
  bit done_bad = 0, prev_done = 0, prev_cs = 1, early_ready = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) begin
        done_cnt++;
        if (prev_done || cs_n !== 1'b1 || prev_cs !== 1'b0) done_bad = 1;
      end
      if (req_ready && frames == 0) early_ready = 1;
    end
    prev_done = frame_done; prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (req_ready !== 1'b1) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] op, input logic [PW-1:0] pin, input logic val,
                      output logic rv, output logic rd, output logic re);
    wait_ready();
    req_valid = 1; req_op = op; req_pin = pin; req_value = val;
    @(negedge clk);
    req_valid = 0;
    rv = rsp_valid; rd = rsp_data; re = rsp_error;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; req_valid = 0; req_op = 0; req_pin = 0; req_value = 0;
    idle(4);
    chk(cs_n === 1 && sclk === 0, "R2 reset idle link", {cs_n, sclk}, 2'b10);
    chk(oe_n === 1, "R9 oe_n in reset", oe_n, 1);
    chk(req_ready === 0, "R9 not ready in reset", req_ready, 0);
    rst_n = 1;
    idle(3);
    chk(oe_n === 0, "R9 oe_n active after release", oe_n, 0);
    wait_ready();
    chk(frames == 1, "R9 one reset frame", frames, 1);
    chk(!early_ready, "R9 ready after reset frame", early_ready, 0);
    chk(last_frame === DEF, "R9 R3 reset frame content", last_frame, DEF);
    chk(last_bits == NP, "R2 bits per frame", last_bits, NP);
    chk(lmin == DIV * 5 && lmax == DIV * 5, "R10 sclk period", lmax, DIV * 5);
  endtask

  task automatic t_set(input logic [2:0] op, input logic [PW-1:0] pin, input logic val, input string tag);
    logic rv, rd, re;
    int f0;
    f0 = frames;
    send(op, pin, val, rv, rd, re);
    model[pin] = val;
    chk(rv === 1 && re === 0, {tag, " R12 response"}, {rv, re}, 2'b10);
    chk(req_ready === 0, {tag, " R4 busy after set"}, req_ready, 0);
    wait_ready();
    chk(frames == f0 + 1, {tag, " R4 one frame"}, frames, f0 + 1);
    chk(last_frame === model, {tag, " R3 frame content"}, last_frame, model);
    chk(last_bits == NP, {tag, " R2 bit count"}, last_bits, NP);
  endtask

  task automatic t_get(input logic [PW-1:0] pin);
    logic rv, rd, re;
    int f0;
    f0 = frames;
    send(3'd0, pin, 0, rv, rd, re);
    chk(rv === 1 && re === 0 && rd === model[pin], "R5 get value", rd, model[pin]);
    idle(6);
    chk(frames == f0, "R5 get sends nothing", frames, f0);
  endtask

  task automatic t_reject(input logic [2:0] op, input logic [PW-1:0] pin, input string tag);
    logic rv, rd, re;
    int f0;
    f0 = frames;
    send(op, pin, 1, rv, rd, re);
    chk(rv === 1 && re === 1, {tag, " error flag"}, {rv, re}, 2'b11);
    idle(6);
    chk(frames == f0, {tag, " no frame"}, frames, f0);
  endtask

  task automatic t_query();
    logic rv, rd, re;
    int f0;
    f0 = frames;
    send(3'd4, 7, 0, rv, rd, re);
    chk(rv === 1 && rd === 1 && re === 0, "R7 query reports output", {rv, rd, re}, 3'b110);
    idle(6);
    chk(frames == f0, "R7 query no frame", frames, f0);
  endtask

  task automatic t_backtoback();
    int f0, facc;
    f0 = frames;
    wait_ready();
    req_valid = 1; req_op = 1; req_pin = 5; req_value = 1;
    @(negedge clk);
    model[5] = 1;
    req_op = 1; req_pin = 6; req_value = 1;
    while (req_ready !== 1'b1) @(negedge clk);
    facc = frames;
    @(negedge clk);
    req_valid = 0;
    model[6] = 1;
    chk(facc == f0 + 1, "R4 held request waits for frame end", facc, f0 + 1);
    wait_ready();
    chk(frames == f0 + 2 && last_frame === model, "R4 second frame content", last_frame, model);
  endtask

  initial begin
    model = DEF;
    t_reset();
    t_set(3'd1, 0, 0, "R4 pin0 clear");
    t_set(3'd1, 23, 0, "R3 far pin clear");
    t_set(3'd1, 9, 1, "R3 middle pin set");
    t_get(9); t_get(23); t_get(2);
    t_set(3'd2, 16, 0, "R8 make-output");
    t_reject(3'd3, 4, "R6 make-input");
    t_get(4);
    t_reject(3'd1, 26, "R1 pin out of range");
    t_reject(3'd6, 3, "R8 unknown op");
    t_query();
    t_backtoback();
    t_get(6);
    chk(done_cnt == frames && !done_bad, "R11 done pulses", done_cnt, frames);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule